// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KiB pages. It reads a directory entry, then a table entry, from memory through a single 32-bit word port with a valid/ready handshake. It sets the accessed flag of each entry it touches, and the dirty flag of the final entry on a write, by writing the updated word back to memory. It then either returns the physical address or reports a page fault with a three-bit cause code. The faulting linear address is kept in a register.

A requester presents one translation at a time while `req_ready` is high. With each request it supplies the linear address, whether the access is a write, whether the requester runs in user mode, the directory base, a write-protect enable and a translation enable. The result appears for exactly one cycle on the `resp_*` outputs. When translation is disabled, the linear address comes straight back with no memory traffic.

Top module: `pgwalk`

## Requirements
- R1: With `xlate_en` low, an accepted request returns `resp_paddr` equal to the linear address with `resp_fault` low, one cycle after acceptance, and makes no memory access.
- R2: The directory entry is read from `dir_base` + 4 × laddr[31:22]. The table entry is read from {directory entry[31:12], laddr[21:12], 2'b00}. A memory request holds its address and direction until `mem_ready` is seen.
- R3: If bit 0 (present) of the directory entry or of the table entry is 0, the walk ends at once with a fault whose code bit 0 is 0. No further memory access follows.
- R4: If a present entry has bit 5 (accessed) at 0, the entry is written back with bit 5 set before the walk continues. The directory entry's write-back comes before the table read. No write-back is made when bit 5 is already 1.
- R5: On success, `resp_paddr` is {table entry[31:12], laddr[11:0]}.
- R6: Rights are merged by AND: writable is bit 1 of both entries, user-accessible is bit 2 of both entries. The check index is {write-protect, user mode, merged user, merged writable, write}, and access is allowed when that bit of 32'hD0DDD0FF is 1.
- R7: In supervisor mode, reads are always allowed. Writes to a non-writable page are allowed only when write-protect is off. In user mode, a page that is not user-accessible is never accessible, and writes need the page to be writable.
- R8: A failed rights check gives a fault whose code bit 0 is 1.
- R9: The fault code has bit 1 = write access and bit 2 = user mode. `fault_addr` takes the faulting linear address and keeps it until the next fault.
- R10: After the rights check passes, a write whose table entry has bit 6 (dirty) at 0 writes the table entry back with bit 6 set. Reads, already-dirty entries and faults produce no such write.
- R11: After reset, `req_ready` is 1, and `resp_valid`, `mem_valid` and `fault_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Requester in user mode |
| xlate_en | input | 1 | Translation enable |
| dir_base | input | 32 | Physical base of the directory |
| wp_en | input | 1 | Write-protect enable for supervisor writes |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_fault | output | 1 | Result is a page fault |
| resp_err | output | 3 | Fault code {user, write, rights violation} |
| resp_paddr | output | 32 | Physical address on success |
| fault_addr | output | 32 | Last faulting linear address |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts / returns data |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A pass-through result is due on the cycle right after acceptance, and the bench checks for it at that exact falling edge. A walked result is due one cycle after the last memory handshake or after the rights check. The number of memory transfers before it depends on the entries' flag bits and on how long `mem_ready` stays low. For this reason, the behavioural model first computes the ordered list of transfers the walk must make. The bench then matches every handshake against the head of that list on the falling edge before the edge that completes it, and any transfer that does not belong to the list is reported. A response is compared when `resp_valid` is seen, and the bench then confirms that no expected transfer was left over.

// File: rtl/pgwalk.sv
module pgwalk #(
  parameter int          AW        = 32,
  parameter logic [31:0] ALLOW_MAP = 32'hD0DDD0FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_laddr,
  input  logic          req_write,
  input  logic          req_user,
  input  logic          xlate_en,
  input  logic [AW-1:0] dir_base,
  input  logic          wp_en,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic [2:0]    resp_err,
  output logic [AW-1:0] resp_paddr,
  output logic [AW-1:0] fault_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  localparam int PB = 0;
  localparam int WB = 1;
  localparam int UB = 2;
  localparam int AB = 5;
  localparam int DB = 6;
  localparam int OFS = 12;
  localparam int IXW = 10;
  localparam logic [AW-1:0] A_MASK = AW'(1) << AB;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_TBL, S_CHECK, S_WB_DIRTY, S_RESP
  } st_t;

  st_t           st;
  logic [AW-1:0] la_q, base_q, dir_q, tbl_q;
  logic          wr_q, us_q, wp_q;
  logic          done;
  logic [4:0]    perm_idx;
  logic          allow;
  logic          dir_phase;

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_RD_DIR) || (st == S_WB_DIR) || (st == S_RD_TBL) ||
                     (st == S_WB_TBL) || (st == S_WB_DIRTY);
  assign mem_write = (st == S_WB_DIR) || (st == S_WB_TBL) || (st == S_WB_DIRTY);
  assign dir_phase = (st == S_RD_DIR) || (st == S_WB_DIR);
  assign mem_addr  = dir_phase
                   ? base_q + {{(AW-IXW-2){1'b0}}, la_q[AW-1 -: IXW], 2'b00}
                   : {dir_q[AW-1:OFS], la_q[OFS+IXW-1:OFS], 2'b00};
  assign mem_wdata = dir_phase ? dir_q : tbl_q;
  assign done      = mem_valid && mem_ready;
  assign perm_idx  = {wp_q, us_q, dir_q[UB] & tbl_q[UB], dir_q[WB] & tbl_q[WB], wr_q};
  assign allow     = ALLOW_MAP[perm_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      la_q       <= '0;
      base_q     <= '0;
      dir_q      <= '0;
      tbl_q      <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      wp_q       <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_err   <= '0;
      resp_paddr <= '0;
      fault_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          la_q   <= req_laddr;
          wr_q   <= req_write;
          us_q   <= req_user;
          wp_q   <= wp_en;
          base_q <= dir_base;
          if (!xlate_en) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_err   <= '0;
            resp_paddr <= req_laddr;
            st         <= S_RESP;
          end else begin
            st <= S_RD_DIR;
          end
        end
        S_RD_DIR: if (done) begin
          dir_q <= mem_rdata | A_MASK;
          if (!mem_rdata[PB]) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_err   <= {us_q, wr_q, 1'b0};
            resp_paddr <= '0;
            fault_addr <= la_q;
            st         <= S_RESP;
          end else if (!mem_rdata[AB]) begin
            st <= S_WB_DIR;
          end else begin
            st <= S_RD_TBL;
          end
        end
        S_WB_DIR: if (done) st <= S_RD_TBL;
        S_RD_TBL: if (done) begin
          tbl_q <= mem_rdata | A_MASK;
          if (!mem_rdata[PB]) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_err   <= {us_q, wr_q, 1'b0};
            resp_paddr <= '0;
            fault_addr <= la_q;
            st         <= S_RESP;
          end else if (!mem_rdata[AB]) begin
            st <= S_WB_TBL;
          end else begin
            st <= S_CHECK;
          end
        end
        S_WB_TBL: if (done) st <= S_CHECK;
        S_CHECK: begin
          if (!allow) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_err   <= {us_q, wr_q, 1'b1};
            resp_paddr <= '0;
            fault_addr <= la_q;
            st         <= S_RESP;
          end else if (wr_q && !tbl_q[DB]) begin
            tbl_q[DB] <= 1'b1;
            st        <= S_WB_DIRTY;
          end else begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_err   <= '0;
            resp_paddr <= {tbl_q[AW-1:OFS], la_q[OFS-1:0]};
            st         <= S_RESP;
          end
        end
        S_WB_DIRTY: if (done) begin
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_err   <= '0;
          resp_paddr <= {tbl_q[AW-1:OFS], la_q[OFS-1:0]};
          st         <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !xlate_en) |=>
      (resp_valid && !resp_fault && resp_paddr == $past(req_laddr)));

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  a_r4_writeback_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> mem_wdata[AB]);

  a_r10_dirty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB_DIRTY) |-> (wr_q && mem_wdata[DB] && mem_write));

  a_r9_fault_record: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (fault_addr == la_q && resp_err[1] == wr_q && resp_err[2] == us_q));
endmodule

// File: tb/test_pgwalk.sv
`timescale 1ns/1ps
module test_pgwalk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        xlate_en = 1'b0;
  logic [31:0] dir_base = '0;
  logic        wp_en = 1'b0;
  logic        resp_valid, resp_fault;
  logic [2:0]  resp_err;
  logic [31:0] resp_paddr, fault_addr;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pgwalk i_pgwalk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .xlate_en(xlate_en), .dir_base(dir_base), .wp_en(wp_en),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_err(resp_err),
    .resp_paddr(resp_paddr), .fault_addr(fault_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic [31:0] a;
    bit          we;
    logic [31:0] d;
  } txn_t;

  logic [31:0] mem [logic [31:0]];
  txn_t        exp_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  bit          exp_fault;
  logic [2:0]  exp_err;
  logic [31:0] exp_paddr;
  logic [31:0] exp_fa = '0;
  string       cur_tag = "";

  localparam logic [31:0] BASE = 32'h0001_0000;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] la, input bit wr, input bit usr,
                                input bit en, input bit wp);
    logic [31:0] da, d, ta, t;
    bit ok;
    exp_q.delete();
    exp_fault = 1'b0;
    exp_err = '0;
    exp_paddr = la;
    if (!en) return;
    da = BASE + 32'(la[31:22]) * 4;
    d = rd(da);
    exp_q.push_back('{da, 1'b0, 32'h0});
    if (!d[0]) begin
      exp_fault = 1'b1; exp_err = {usr, wr, 1'b0}; exp_fa = la; return;
    end
    if (!d[5]) begin
      d[5] = 1'b1;
      exp_q.push_back('{da, 1'b1, d});
    end
    ta = {d[31:12], 12'h0} + 32'(la[21:12]) * 4;
    t = rd(ta);
    exp_q.push_back('{ta, 1'b0, 32'h0});
    if (!t[0]) begin
      exp_fault = 1'b1; exp_err = {usr, wr, 1'b0}; exp_fa = la; return;
    end
    if (!t[5]) begin
      t[5] = 1'b1;
      exp_q.push_back('{ta, 1'b1, t});
    end
    if (usr && !(d[2] && t[2])) ok = 1'b0;
    else if (!wr) ok = 1'b1;
    else if (d[1] && t[1]) ok = 1'b1;
    else ok = !usr && !wp;
    if (!ok) begin
      exp_fault = 1'b1; exp_err = {usr, wr, 1'b1}; exp_fa = la; return;
    end
    if (wr && !t[6]) begin
      t[6] = 1'b1;
      exp_q.push_back('{ta, 1'b1, t});
    end
    exp_paddr = {t[31:12], la[11:0]};
  endfunction

  always @(negedge clk) begin
    bit rdy;
    txn_t e;
    cyc++;
    rdy = ((cyc % 4) != 1) && ((cyc % 7) != 3);
    mem_ready = rdy;
    mem_rdata = rd(mem_addr);
    if (rst_n && mem_valid && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 R3 R10", {cur_tag, " unexpected memory access"}, mem_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R2", {cur_tag, " access address"}, mem_addr, e.a);
        check(mem_write == e.we, "R4 R10", {cur_tag, " access direction"}, 32'(mem_write), 32'(e.we));
        if (e.we) begin
          check(mem_wdata == e.d, "R4 R10", {cur_tag, " write-back data"}, mem_wdata, e.d);
          mem[mem_addr] = mem_wdata;
        end
      end
    end
    if (rst_n && resp_valid) begin
      check(resp_fault == exp_fault, "R3 R8", {cur_tag, " fault flag"}, 32'(resp_fault), 32'(exp_fault));
      if (exp_fault)
        check(resp_err == exp_err, "R8 R9", {cur_tag, " fault code"}, 32'(resp_err), 32'(exp_err));
      else
        check(resp_paddr == exp_paddr, "R5", {cur_tag, " physical address"}, resp_paddr, exp_paddr);
      check(fault_addr == exp_fa, "R9", {cur_tag, " fault address"}, fault_addr, exp_fa);
      done = 1'b1;
    end
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run(input logic [31:0] la, input bit wr, input bit usr, input bit en,
                     input bit wp, input string tag);
    int n;
    @(negedge clk);
    cur_tag = tag;
    model(la, wr, usr, en, wp);
    done = 1'b0;
    req_laddr = la; req_write = wr; req_user = usr; xlate_en = en; wp_en = wp;
    dir_base = BASE;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!en) begin
      check(resp_valid === 1'b1, "R1", {tag, " bypass latency"}, 32'(resp_valid), 32'h1);
      check(mem_valid === 1'b0, "R1", {tag, " bypass memory idle"}, 32'(mem_valid), 32'h0);
    end
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(done, "R2", {tag, " response arrived"}, 32'(done), 32'h1);
    check(exp_q.size() == 0, "R4 R10", {tag, " all expected accesses made"},
          32'(exp_q.size()), 32'h0);
  endtask

  // entry helpers: P=1, W=2, U=4, A=0x20, D=0x40
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R11", "reset ready", 32'(req_ready), 32'h1);
    check(resp_valid === 1'b0, "R11", "reset resp_valid", 32'(resp_valid), 32'h0);
    check(mem_valid === 1'b0, "R11", "reset mem_valid", 32'(mem_valid), 32'h0);
    check(fault_addr === 32'h0, "R11", "reset fault_addr", fault_addr, 32'h0);

    run(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b1, "R1 bypass write");
    run(32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b0, "R1 bypass read");

    // R3: directory entry absent
    run(32'h0140_2123, 1'b1, 1'b1, 1'b1, 1'b0, "R3 dir absent");
    // R3: table entry absent
    mem[BASE + 4*6] = 32'h0002_0007;
    run(32'h0180_5010, 1'b0, 1'b0, 1'b1, 1'b0, "R3 table absent");
    // R4 R5: both accessed flags clear, supervisor read
    mem[BASE + 4*7] = 32'h0002_1007;
    mem[32'h0002_1000 + 4*9] = 32'h0ABC_D007;
    run(32'h01C0_9ABC, 1'b0, 1'b0, 1'b1, 1'b1, "R4 R5 first walk");
    run(32'h01C0_9FFF, 1'b0, 1'b1, 1'b1, 1'b1, "R4 second walk no write-back");
    // R10: user write to writable user page, clean
    run(32'h01C0_9004, 1'b1, 1'b1, 1'b1, 1'b1, "R10 dirty write-back");
    run(32'h01C0_9008, 1'b1, 1'b1, 1'b1, 1'b1, "R10 already dirty");
    // R7: supervisor write to read-only page
    mem[BASE + 4*8] = 32'h0002_2025;
    mem[32'h0002_2000 + 4*1] = 32'h0055_5025;
    run(32'h0200_1010, 1'b1, 1'b0, 1'b1, 1'b1, "R7 R8 sup write ro wp on");
    run(32'h0200_1010, 1'b1, 1'b0, 1'b1, 1'b0, "R7 sup write ro wp off");
    run(32'h0200_1020, 1'b1, 1'b1, 1'b1, 1'b0, "R7 R8 user write ro");
    // R7: user read of supervisor page
    mem[32'h0002_2000 + 4*2] = 32'h0066_6023;
    run(32'h0200_2000, 1'b0, 1'b1, 1'b1, 1'b0, "R7 R9 user read sup page");
    run(32'h0200_2044, 1'b0, 1'b0, 1'b1, 1'b1, "R9 fault addr held");

    // R6: sweep of merged rights, mode, operation and write-protect
    for (int k = 0; k < 128; k++) begin
      logic [31:0] de, te;
      de = 32'h0002_3001 | (k[0] ? 32'h2 : 0) | (k[1] ? 32'h4 : 0) | (k[6] ? 32'h20 : 0);
      te = 32'h0077_0001 | (k[2] ? 32'h2 : 0) | (k[3] ? 32'h4 : 0) | (k[5] ? 32'h40 : 0);
      mem[BASE + 4*9] = de;
      mem[32'h0002_3000 + 4*5] = te;
      run(32'h0240_5000 | 32'(k * 4), k[4], k[5] ^ k[0], 1'b1, k[6] ^ k[3], "R6 R7 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule